// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a memory-mapped watchdog peripheral. Software reaches it through a 32-bit register bus with an address, a write strobe, write data and combinational read data. A base tick input, nominally one pulse per microsecond, drives a programmable prescaler. The prescaler in turn decrements a 16-bit down-counter.

Software first programs a reload value and a prescaler period, then issues a restart command and sets the enable bit. From then on it must repeat the restart command before the counter drains. If the counter reaches zero while enabled, the block drives a fixed-length reset pulse toward the system reset controller and clears its own enable bit. It also sets a sticky cause flag. Boot code reads that flag to tell a watchdog reset apart from other reset causes, and clears it by writing a one to it.

Clearing the enable bit freezes the countdown without any reset. The prescaler and reload value can then be reprogrammed safely, and a restart followed by enable starts a fresh, full-length countdown.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, the status word (offset 0x00) reads 0, the control word (offset 0x20) reads 0x0001_0000 (disabled, prescaler period 1), the load word (offset 0x24) reads 0x0000_FFFF, and `wdt_rst_o` is low.
- R2: The control word holds the enable bit at bit 7 and a 16-bit prescaler period in bits 31:16, and both read back as written. The load word keeps only bits 15:0 of a write, and its bits 31:16 read as zero.
- R3: While enabled, the down-counter drops by one after every P base ticks, where P is the prescaler period and a period of 0 acts as 1. Cycles without a tick do not advance the count, and ticks while disabled do not advance it either.
- R4: A write to offset 0x00 with bit 9 set reloads the down-counter from the load word and restarts the prescaler phase. This works whether or not the timer is enabled, and the write stores nothing that reads back.
- R5: When the timer is enabled and the down-counter is zero, `wdt_rst_o` goes high in the next cycle and stays high for exactly 16 cycles, and the enable bit reads 0 from then on.
- R6: Expiry sets the cause flag at bit 1 of the status word. The flag is cleared only by a write to offset 0x00 with bit 1 set or by power-on reset, and other writes to that offset leave it unchanged.
- R7: Clearing the enable bit freezes the down-counter with no reset pulse, however long the block is then left running.
- R8: Reads of any offset other than 0x00, 0x20 and 0x24 return zero, and writes to them change no register.
- R9: Setting the enable bit while the timer is disabled restarts the prescaler phase, so the first decrement comes a full period of ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_i | input | 1 | Base tick, one-cycle pulse |
| wdt_rst_o | output | 1 | Reset request to the system reset controller |

## Verification
The bound checker covers four behaviours on every cycle. It checks that each expiry produces the pulse, clears the enable bit and sets the cause flag in the following cycle. It checks that a disabled timer's counter holds still apart from restarts, that a restart loads the reload value and a decrement removes exactly one, and that the cause flag survives every write except a clear. It also checks that unmapped offsets read as zero. Only the bench's scenarios can show the end-to-end timing, because the counter itself is not visible at the ports. This covers the number of ticks from restart to expiry for a given prescaler period, the exact 16-cycle pulse width, the keep-alive pattern that never expires, and the phase restart on enable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  // Offsets and bit positions that software decodes
  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h00;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 8'h20;
  localparam logic [REG_AW-1:0] OFS_LOAD   = 8'h24;

  localparam int BIT_CAUSE   = 1;
  localparam int BIT_ENABLE  = 7;
  localparam int BIT_RESTART = 9;
  localparam int PRESC_LSB   = 16;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_CTRL,
    SEL_LOAD
  } reg_sel_e;

  function automatic reg_sel_e wdog_decode(input logic [REG_AW-1:0] addr);
    reg_sel_e sel;
    unique case (addr)
      OFS_STATUS: sel = SEL_STATUS;
      OFS_CTRL:   sel = SEL_CTRL;
      OFS_LOAD:   sel = SEL_LOAD;
      default:    sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int PRESC_W   = 16,
  parameter int CNT_W     = 16,
  parameter int PRESC_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              expire_i,
  output logic              en_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              cause_o,
  output logic              restart_o,
  output logic              en_rise_o
);

  reg_sel_e sel;
  logic wr_status, wr_ctrl, wr_load, clr_cause;

  logic              en_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]  load_q;
  logic              cause_q;

  always_comb begin
    sel       = wdog_decode(reg_addr);
    wr_status = reg_we && (sel == SEL_STATUS);
    wr_ctrl   = reg_we && (sel == SEL_CTRL);
    wr_load   = reg_we && (sel == SEL_LOAD);
  end

  assign restart_o = wr_status && reg_wdata[BIT_RESTART];
  assign clr_cause = wr_status && reg_wdata[BIT_CAUSE];
  assign en_rise_o = wr_ctrl && reg_wdata[BIT_ENABLE] && !en_q;

  // Enable: expiry takes priority over a same-cycle control write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (expire_i) begin
      en_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= reg_wdata[BIT_ENABLE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= PRESC_W'(PRESC_RST);
    end else if (wr_ctrl) begin
      presc_q <= reg_wdata[PRESC_LSB +: PRESC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '1;
    end else if (wr_load) begin
      load_q <= reg_wdata[CNT_W-1:0];
    end
  end

  // Sticky cause flag: set on expiry, cleared by write-one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
    end else if (expire_i) begin
      cause_q <= 1'b1;
    end else if (clr_cause) begin
      cause_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_STATUS: reg_rdata[BIT_CAUSE] = cause_q;
      SEL_CTRL: begin
        reg_rdata[BIT_ENABLE]             = en_q;
        reg_rdata[PRESC_LSB +: PRESC_W]   = presc_q;
      end
      SEL_LOAD:   reg_rdata[CNT_W-1:0]    = load_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign en_o    = en_q;
  assign presc_o = presc_q;
  assign load_o  = load_q;
  assign cause_o = cause_q;

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               clear_i,
  output logic               step_o
);

  localparam int DIV_W = PRESC_W + 1;

  // True when this tick completes a prescaler period (period 0 acts as 1)
  function automatic logic period_done(input logic [PRESC_W-1:0] div,
                                       input logic [PRESC_W-1:0] presc);
    logic [DIV_W-1:0] next_div;
    logic [DIV_W-1:0] limit;
    next_div = DIV_W'(div) + DIV_W'(1);
    limit    = (presc == '0) ? DIV_W'(1) : DIV_W'(presc);
    return next_div >= limit;
  endfunction

  logic [PRESC_W-1:0] div_q;
  logic               advance;
  logic               wrap;

  assign advance = en_i && tick_i;
  assign wrap    = period_done(div_q, presc_i);
  assign step_o  = advance && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clear_i) begin
      div_q <= '0;
    end else if (advance) begin
      div_q <= wrap ? '0 : div_q + PRESC_W'(1);
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (restart_i) begin
      cnt_q <= load_i;
    end else if (step_i && !expire_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic rst_o
);

  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire_i) begin
      left_q <= PW'(PULSE_LEN);
    end else if (left_q != '0) begin
      left_q <= left_q - PW'(1);
    end
  end

  assign rst_o = (left_q != '0);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int PRESC_W   = 16,
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 16,
  parameter int PRESC_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              tick_i,
  output logic              wdt_rst_o
);

  // Named internal events, visible to the bound checker
  logic               en_w;
  logic [PRESC_W-1:0] presc_w;
  logic [CNT_W-1:0]   load_w;
  logic               cause_w;
  logic               restart_w;
  logic               en_rise_w;
  logic               step_w;
  logic [CNT_W-1:0]   cnt_w;
  logic               expire_w;
  logic               phase_clr_w;

  assign phase_clr_w = restart_w || en_rise_w;

  wdog_regs #(
    .PRESC_W  (PRESC_W),
    .CNT_W    (CNT_W),
    .PRESC_RST(PRESC_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .expire_i (expire_w),
    .en_o     (en_w),
    .presc_o  (presc_w),
    .load_o   (load_w),
    .cause_o  (cause_w),
    .restart_o(restart_w),
    .en_rise_o(en_rise_w)
  );

  wdog_prescaler #(
    .PRESC_W(PRESC_W)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_w),
    .tick_i (tick_i),
    .presc_i(presc_w),
    .clear_i(phase_clr_w),
    .step_o (step_w)
  );

  wdog_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_w),
    .step_i   (step_w),
    .restart_i(restart_w),
    .load_i   (load_w),
    .cnt_o    (cnt_w),
    .expire_o (expire_w)
  );

  wdog_rstgen #(
    .PULSE_LEN(PULSE_LEN)
  ) u_rstgen (
    .clk   (clk),
    .rst_n (rst_n),
    .fire_i(expire_w),
    .rst_o (wdt_rst_o)
  );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_we,
  input logic [REG_DW-1:0] reg_wdata,
  input logic [REG_DW-1:0] reg_rdata,
  input logic              wdt_rst_o,
  input logic              en,
  input logic              cause,
  input logic              restart,
  input logic              step,
  input logic              expire,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load
);

  logic unmapped;
  logic cause_clear_wr;

  assign unmapped = (reg_addr != OFS_STATUS) && (reg_addr != OFS_CTRL) &&
                    (reg_addr != OFS_LOAD);
  assign cause_clear_wr = reg_we && (reg_addr == OFS_STATUS) && reg_wdata[BIT_CAUSE];

  // R5: expiry raises the reset pulse and drops enable in the next cycle
  a_r5_expire_fires: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (wdt_rst_o && !en));

  // R5: no pulse starts without an expiry
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_rst_o && !expire) |=> !wdt_rst_o);

  // R6: expiry sets the cause flag
  a_r6_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cause);

  // R6: only a write-one clears the cause flag
  a_r6_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cause && !cause_clear_wr) |=> cause);

  // R7: disabled counter holds unless restarted
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> $stable(cnt));

  // R4: restart loads the reload value
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == $past(load)));

  // R3: a prescaler step removes exactly one
  a_r3_single_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !expire) |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

  // R8: unmapped offsets read as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (reg_rdata == '0));

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_we   (reg_we),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .wdt_rst_o(wdt_rst_o),
  .en       (en_w),
  .cause    (cause_w),
  .restart  (restart_w),
  .step     (step_w),
  .expire   (expire_w),
  .cnt      (cnt_w),
  .load     (load_w)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_i = 1'b0;
  logic        wdt_rst_o;

  always #2 clk = ~clk;

  wdog_timer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .tick_i   (tick_i),
    .wdt_rst_o(wdt_rst_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string tag   = "R1";
  logic [31:0] obs_rd;
  logic        obs_rst;
  int          rst_seen;

  // Reference model state
  int m_en, m_presc, m_load, m_cnt, m_div, m_cause, m_pulse;

  task automatic model_reset();
    m_en = 0; m_presc = 1; m_load = 16'hFFFF; m_cnt = 16'hFFFF;
    m_div = 0; m_cause = 0; m_pulse = 0;
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 8'h00) v = m_cause ? 32'h2 : 32'h0;
    else if (a == 8'h20) v = (32'(m_presc) << 16) | (m_en ? 32'h80 : 32'h0);
    else if (a == 8'h24) v = 32'(m_load);
    return v;
  endfunction

  task automatic model_step(input bit we, input logic [7:0] a,
                            input logic [31:0] d, input bit tk);
    bit expire, restart, wctrl, wload, w1c, step, rise;
    int lim;
    expire  = (m_en != 0) && (m_cnt == 0);
    restart = we && a == 8'h00 && d[9];
    w1c     = we && a == 8'h00 && d[1];
    wctrl   = we && a == 8'h20;
    wload   = we && a == 8'h24;
    rise    = wctrl && d[7] && (m_en == 0);
    lim     = (m_presc == 0) ? 1 : m_presc;
    step    = (m_en != 0) && tk && (m_div + 1 >= lim);
    if (restart || rise) m_div = 0;
    else if (m_en != 0 && tk) m_div = step ? 0 : m_div + 1;
    if (restart) m_cnt = m_load;
    else if (step && !expire) m_cnt = m_cnt - 1;
    if (expire) m_en = 0;
    else if (wctrl) m_en = d[7];
    if (wctrl) m_presc = int'(d[31:16]);
    if (wload) m_load = int'(d[15:0]);
    if (expire) m_cause = 1;
    else if (w1c) m_cause = 0;
    if (expire) m_pulse = 16;
    else if (m_pulse > 0) m_pulse = m_pulse - 1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus cycle: drive after negedge, compare, then advance the model at posedge
  task automatic cycle(input bit we, input logic [7:0] a,
                       input logic [31:0] d, input bit tk);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; tick_i = tk;
    #1;
    obs_rd  = reg_rdata;
    obs_rst = wdt_rst_o;
    if (obs_rst) rst_seen++;
    check({tag, " rdata"}, obs_rd, model_read(a));
    check({tag, " rst"}, {31'b0, obs_rst}, {31'b0, m_pulse > 0});
    @(posedge clk);
    model_step(we, a, d, tk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cycle(1'b1, a, d, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a);
    cycle(1'b0, a, 32'h0, 1'b0);
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 32'h0, tk);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    tag = "R1";
    rd(8'h00); check("R1 status", obs_rd, 32'h0);
    rd(8'h20); check("R1 ctrl", obs_rd, 32'h0001_0000);
    rd(8'h24); check("R1 load", obs_rd, 32'h0000_FFFF);
    check("R1 rst_o", {31'b0, obs_rst}, 32'h0);

    // R8: unmapped offsets
    tag = "R8";
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10); check("R8 unmapped read", obs_rd, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h20); check("R8 ctrl untouched", obs_rd, 32'h0001_0000);
    rd(8'h24); check("R8 load untouched", obs_rd, 32'h0000_FFFF);

    // R2: field layout
    tag = "R2";
    wr(8'h24, 32'hABCD_1234);
    rd(8'h24); check("R2 load low half", obs_rd, 32'h0000_1234);
    wr(8'h20, 32'h0003_0000);
    rd(8'h20); check("R2 ctrl presc", obs_rd, 32'h0003_0000);

    // R4: restart while disabled, stores nothing
    tag = "R4";
    wr(8'h24, 32'h0000_0006);
    wr(8'h00, 32'h0000_0200);
    rd(8'h00); check("R4 status stores nothing", obs_rd, 32'h0);

    // R5: expiry after 6 periods of 3 ticks, 16-cycle pulse
    tag = "R5";
    wr(8'h20, 32'h0003_0080);
    rst_seen = 0;
    idle(60, 1'b1);
    check("R5 pulse width", 32'(rst_seen), 32'd16);
    rd(8'h20); check("R5 enable cleared", obs_rd, 32'h0003_0000);

    // R6: cause flag sticky, write-one clear
    tag = "R6";
    rd(8'h00); check("R6 cause set", obs_rd, 32'h2);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00); check("R6 write zero keeps", obs_rd, 32'h2);
    wr(8'h00, 32'h0000_0200);
    rd(8'h00); check("R6 restart keeps", obs_rd, 32'h2);
    wr(8'h00, 32'h0000_0002);
    rd(8'h00); check("R6 w1c clears", obs_rd, 32'h0);

    // R7: disable freezes without reset
    tag = "R7";
    wr(8'h24, 32'h0000_000A);
    wr(8'h00, 32'h0000_0200);
    wr(8'h20, 32'h0002_0080);
    idle(8, 1'b1);
    wr(8'h20, 32'h0002_0000);
    rst_seen = 0;
    idle(120, 1'b1);
    check("R7 no reset while disabled", 32'(rst_seen), 32'd0);
    wr(8'h20, 32'h0002_0080);
    idle(40, 1'b1);
    wr(8'h00, 32'h0000_0002);

    // R3: no ticks means no countdown; period 0 acts as 1
    tag = "R3";
    wr(8'h24, 32'h0000_0003);
    wr(8'h00, 32'h0000_0200);
    wr(8'h20, 32'h0001_0080);
    rst_seen = 0;
    idle(50, 1'b0);
    check("R3 no ticks no expiry", 32'(rst_seen), 32'd0);
    idle(30, 1'b1);
    check("R3 ticks expire", 32'(rst_seen), 32'd16);
    wr(8'h00, 32'h0000_0202);
    wr(8'h20, 32'h0000_0080);
    for (int i = 0; i < 40; i++) cycle(1'b0, 8'h20, 32'h0, (i % 3) == 0);

    // R4: keep-alive restarts prevent expiry
    tag = "R4";
    wr(8'h00, 32'h0000_0002);
    wr(8'h24, 32'h0000_0005);
    wr(8'h00, 32'h0000_0200);
    wr(8'h20, 32'h0002_0080);
    rst_seen = 0;
    for (int k = 0; k < 30; k++) begin
      idle(6, 1'b1);
      wr(8'h00, 32'h0000_0200);
    end
    check("R4 keep-alive no reset", 32'(rst_seen), 32'd0);
    wr(8'h20, 32'h0002_0000);

    // R9: enable rise restarts prescaler phase
    tag = "R9";
    wr(8'h24, 32'h0000_0002);
    wr(8'h00, 32'h0000_0200);
    wr(8'h20, 32'h0004_0080);
    idle(3, 1'b1);
    wr(8'h20, 32'h0004_0000);
    cycle(1'b1, 8'h20, 32'h0004_0080, 1'b0);
    idle(40, 1'b1);
    rd(8'h00); check("R9 expired after phase restart", obs_rd, 32'h2);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule